// File: doc/BRIEF.md
# Parallel Plane-Equation Pixel Array

This block is a grid of pixel cells that all evaluate the same linear form V = A*x + B*y + C at once, where x is a cell's column and y its row. The three coefficients are broadcast bit-serially, one bit of each per cycle, and every cell acts on its own value of V. Each cell keeps an enable flag, a pass flag, a signed depth and three 8-bit colour channels.

A host first starts a command with an opcode, then shifts A, B and C in on three serial lines. One cycle after the last bit has been taken, every cell applies the command to its own V.

A triangle is drawn in seven passes. Three edge passes clip away every cell on the outer side of a bounding line. One depth pass runs a nearer-than test against the stored depth. Three colour passes load the interpolated red, green and blue planes. When the array is idle, a read port returns any cell's stored colour by its address.

Top module: `plane_eval_array`

## Requirements
- R1: After reset every enable is set, every pass flag is clear, every depth holds the farthest value (2^(SUM_W-1)-1), every colour is zero, `busy` and `done` are low and `rd_rgb` is zero.
- R2: A command is accepted when `start` is high while `busy` is low. Bit k of A, B and C (LSB first, 16-bit two's complement) is sampled on `a_bit`, `b_bit` and `c_bit` at the (k+1)-th rising edge after the accepting edge. `busy` is high from the accepting edge until the command takes effect. `done` is high for exactly one cycle, COEF_W+1 edges after the accepting edge, with `busy` low. A `start` seen while `busy` is high is ignored.
- R3: The cell at column x and row y, read at address y*GRID_W+x, evaluates V = A*x + B*y + C, sign-extended to SUM_W bits.
- R4: Opcode 1 (edge) clears the enable of every cell whose V is negative. A cell with V equal to zero keeps its enable.
- R5: Opcode 0 sets the enable of every cell.
- R6: Opcode 2 (depth) sets each cell's pass flag to (enable AND V < stored depth), and where the flag is set it stores V as the new depth. A cell whose V equals its stored depth does not pass.
- R7: Opcodes 3, 4 and 5 write red, green and blue respectively, only in cells where both enable and pass are set. The value written is V saturated to the range 0..255.
- R8: Opcode 6 (clear) sets every depth to the farthest value, every colour to zero and every pass flag to zero, and leaves the enables unchanged.
- R9: `rd_rgb` = {red, green, blue} of the cell at `rd_addr` is registered at each rising edge while the array is idle. While `busy` is high it holds its value.
- R10: Opcode 7 leaves all enables, pass flags, depths and colours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command (taken only when idle) |
| opcode | input | 3 | Command code, sampled with `start` |
| a_bit | input | 1 | Serial A coefficient, LSB first |
| b_bit | input | 1 | Serial B coefficient, LSB first |
| c_bit | input | 1 | Serial C coefficient, LSB first |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command has taken effect |
| rd_addr | input | 6 | Cell address y*GRID_W+x for read-out |
| rd_rgb | output | 24 | Stored colour {R,G,B} of the addressed cell |

## Verification
The hardest state to reach from the ports is a depth tie: the new V of an enabled cell exactly equals its stored depth, and that cell must then refuse the following colour write. The stimulus reaches it in two steps. A first triangle writes a flat depth of 100. A second, overlapping triangle then uses a depth plane that crosses 100 exactly on one row, so that the row's colour reveals whether the tie was rejected. A second hard case is a `start` raised with a different opcode in the middle of a coefficient stream, while the read address is moved at the same time. The image and the held `rd_rgb` afterwards show that neither the command nor the read was disturbed.

// File: rtl/pea_pkg.sv
package pea_pkg;
   typedef enum logic [2:0] {
      OP_EN_ALL = 3'd0,
      OP_EDGE   = 3'd1,
      OP_DEPTH  = 3'd2,
      OP_RED    = 3'd3,
      OP_GREEN  = 3'd4,
      OP_BLUE   = 3'd5,
      OP_CLEAR  = 3'd6,
      OP_NOP    = 3'd7
   } pea_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_APPLY = 2'd2
   } pea_state_e;
endpackage

// File: rtl/pea_ctrl.sv
module pea_ctrl
   import pea_pkg::*;
#(
   parameter int COEF_W = 16,
   parameter int IDX_W  = $clog2(COEF_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       opcode,
   output logic             busy,
   output logic             done,
   output logic             acc_clr,
   output logic             shift_en,
   output logic             is_msb,
   output logic [IDX_W-1:0] bit_idx,
   output logic             apply,
   output pea_op_e          op
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(COEF_W - 1);

   pea_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_idx <= '0;
         op      <= OP_NOP;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               op      <= pea_op_e'(opcode);
               bit_idx <= '0;
               state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (bit_idx == LAST) state_q <= ST_APPLY;
               else                 bit_idx <= bit_idx + 1'b1;
            end
            ST_APPLY: begin
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign acc_clr  = (state_q == ST_IDLE) && start;
   assign shift_en = (state_q == ST_SHIFT);
   assign is_msb   = (bit_idx == LAST);
   assign apply    = (state_q == ST_APPLY);
endmodule

// File: rtl/pea_axis_acc.sv
module pea_axis_acc #(
   parameter int COEF_W = 16,
   parameter int SUM_W  = 24,
   parameter int IDX_W  = $clog2(COEF_W),
   parameter int MULT   = 0,
   parameter bit USE_C  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    shift_en,
   input  logic                    is_msb,
   input  logic [IDX_W-1:0]        bit_idx,
   input  logic                    m_bit,
   input  logic                    c_bit,
   output logic signed [SUM_W-1:0] sum
);
   localparam logic signed [SUM_W-1:0] M_EXT = SUM_W'(MULT);
   localparam logic signed [SUM_W-1:0] ONE   = SUM_W'(1);

   logic signed [SUM_W-1:0] term_m, term_c, term;

   assign term_m = m_bit ? (M_EXT << bit_idx) : '0;

   generate
      if (USE_C) begin : g_with_c
         assign term_c = c_bit ? (ONE << bit_idx) : '0;
      end else begin : g_no_c
         logic unused_c;
         assign unused_c = c_bit;
         assign term_c   = '0;
      end
   endgenerate

   assign term = term_m + term_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sum <= '0;
      else if (clr)      sum <= '0;
      else if (shift_en) sum <= is_msb ? (sum - term) : (sum + term);
   end
endmodule

// File: rtl/pea_cell.sv
module pea_cell
   import pea_pkg::*;
#(
   parameter int SUM_W = 24,
   parameter int COL_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    apply,
   input  pea_op_e                 op,
   input  logic signed [SUM_W-1:0] value,
   output logic [3*COL_W-1:0]      rgb
);
   localparam logic signed [SUM_W-1:0] DEPTH_FAR = {1'b0, {(SUM_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] CMAX      = SUM_W'((1 << COL_W) - 1);

   logic                    en_q, pass_q, nearer;
   logic signed [SUM_W-1:0] depth_q;
   logic [COL_W-1:0]        r_q, g_q, b_q, sat_v;

   assign nearer = en_q && (value < depth_q);
   assign sat_v  = (value < 0) ? '0 :
                   (value > CMAX) ? {COL_W{1'b1}} : value[COL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b1;
         pass_q  <= 1'b0;
         depth_q <= DEPTH_FAR;
         r_q     <= '0;
         g_q     <= '0;
         b_q     <= '0;
      end else if (apply) begin
         case (op)
            OP_EN_ALL: en_q <= 1'b1;
            OP_EDGE:   if (value < 0) en_q <= 1'b0;
            OP_DEPTH: begin
               pass_q <= nearer;
               if (nearer) depth_q <= value;
            end
            OP_RED:    if (en_q && pass_q) r_q <= sat_v;
            OP_GREEN:  if (en_q && pass_q) g_q <= sat_v;
            OP_BLUE:   if (en_q && pass_q) b_q <= sat_v;
            OP_CLEAR: begin
               depth_q <= DEPTH_FAR;
               pass_q  <= 1'b0;
               r_q     <= '0;
               g_q     <= '0;
               b_q     <= '0;
            end
            default: ;
         endcase
      end
   end

   assign rgb = {r_q, g_q, b_q};
endmodule

// File: rtl/plane_eval_array.sv
module plane_eval_array
   import pea_pkg::*;
#(
   parameter int GRID_W = 8,
   parameter int GRID_H = 8,
   parameter int COEF_W = 16,
   parameter int SUM_W  = 24,
   parameter int COL_W  = 8,
   parameter int CELLS  = GRID_W * GRID_H,
   parameter int ADDR_W = $clog2(CELLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         opcode,
   input  logic               a_bit,
   input  logic               b_bit,
   input  logic               c_bit,
   output logic               busy,
   output logic               done,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [3*COL_W-1:0] rd_rgb
);
   localparam int IDX_W = $clog2(COEF_W);
   localparam int SPAN  = (GRID_W > GRID_H) ? GRID_W : GRID_H;

   generate
      if (SUM_W < COEF_W + $clog2(SPAN) + 2) begin : g_bad_sum_w
         $error("SUM_W too narrow for COEF_W and grid size");
      end
      if (GRID_W < 2 || GRID_H < 2) begin : g_bad_grid
         $error("grid must be at least 2x2");
      end
      if (COL_W > SUM_W - 2) begin : g_bad_col_w
         $error("COL_W must be narrower than SUM_W");
      end
   endgenerate

   logic             acc_clr, shift_en, is_msb, apply;
   logic [IDX_W-1:0] bit_idx;
   pea_op_e          op;

   pea_ctrl #(.COEF_W(COEF_W), .IDX_W(IDX_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .busy(busy), .done(done), .acc_clr(acc_clr), .shift_en(shift_en),
      .is_msb(is_msb), .bit_idx(bit_idx), .apply(apply), .op(op)
   );

   logic signed [SUM_W-1:0] col_sum [GRID_W];
   logic signed [SUM_W-1:0] row_sum [GRID_H];
   logic [3*COL_W-1:0]      cell_rgb [CELLS];

   generate
      for (genvar gx = 0; gx < GRID_W; gx++) begin : g_col
         pea_axis_acc #(.COEF_W(COEF_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
                        .MULT(gx), .USE_C(1'b0)) acc_i (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .shift_en(shift_en),
            .is_msb(is_msb), .bit_idx(bit_idx), .m_bit(a_bit), .c_bit(1'b0),
            .sum(col_sum[gx])
         );
      end
      for (genvar gy = 0; gy < GRID_H; gy++) begin : g_row
         pea_axis_acc #(.COEF_W(COEF_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
                        .MULT(gy), .USE_C(1'b1)) acc_i (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .shift_en(shift_en),
            .is_msb(is_msb), .bit_idx(bit_idx), .m_bit(b_bit), .c_bit(c_bit),
            .sum(row_sum[gy])
         );
      end
      for (genvar gy = 0; gy < GRID_H; gy++) begin : g_y
         for (genvar gx = 0; gx < GRID_W; gx++) begin : g_x
            logic signed [SUM_W-1:0] v;
            assign v = col_sum[gx] + row_sum[gy];
            pea_cell #(.SUM_W(SUM_W), .COL_W(COL_W)) cell_i (
               .clk(clk), .rst_n(rst_n), .apply(apply), .op(op),
               .value(v), .rgb(cell_rgb[gy*GRID_W + gx])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_rgb <= '0;
      else if (!busy) rd_rgb <= cell_rgb[rd_addr];
   end
endmodule

// File: rtl/pea_checker.sv
module pea_checker #(
   parameter int COEF_W = 16,
   parameter int RGB_W  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [RGB_W-1:0] rd_rgb
);
   logic [15:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (!busy) busy_cnt <= '0;
      else           busy_cnt <= busy_cnt + 1'b1;
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R2
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R2
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cnt == 16'(COEF_W + 1))); // R2
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rd_rgb)); // R9
endmodule

bind plane_eval_array pea_checker #(.COEF_W(COEF_W), .RGB_W(3*COL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_rgb(rd_rgb)
);

// File: tb/plane_eval_array_tb_top.sv
module plane_eval_array_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W      = 8;
   localparam int H      = 8;
   localparam int N      = W * H;
   localparam int CW     = 16;
   localparam int DEPMAX = (1 << 23) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] opcode = 3'd7;
   logic       a_bit = 1'b0, b_bit = 1'b0, c_bit = 1'b0;
   logic       busy, done;
   logic [5:0] rd_addr = '0;
   logic [23:0] rd_rgb;

   int errors = 0;
   int checks = 0;

   bit m_en [N];
   bit m_pass [N];
   int m_dep [N];
   int m_r [N];
   int m_g [N];
   int m_b [N];
   int rd_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   plane_eval_array dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .a_bit(a_bit), .b_bit(b_bit), .c_bit(c_bit), .busy(busy), .done(done),
      .rd_addr(rd_addr), .rd_rgb(rd_rgb)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int sat8(int v);
      if (v < 0) return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   task automatic model_apply(int op, int a, int b, int c);
      for (int i = 0; i < N; i++) begin
         int v;
         v = a * (i % W) + b * (i / W) + c;
         case (op)
            0: m_en[i] = 1'b1;
            1: if (v < 0) m_en[i] = 1'b0;
            2: begin
               m_pass[i] = m_en[i] && (v < m_dep[i]);
               if (m_pass[i]) m_dep[i] = v;
            end
            3: if (m_en[i] && m_pass[i]) m_r[i] = sat8(v);
            4: if (m_en[i] && m_pass[i]) m_g[i] = sat8(v);
            5: if (m_en[i] && m_pass[i]) m_b[i] = sat8(v);
            6: begin
               m_dep[i] = DEPMAX; m_pass[i] = 1'b0;
               m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
            end
            default: ;
         endcase
      end
   endtask

   // Runs one command; poke raises start with CLEAR mid-stream and moves rd_addr.
   task automatic run_cmd(int op, int a, int b, int c, bit poke);
      logic [15:0] av, bv, cv;
      av = 16'(a); bv = 16'(b); cv = 16'(c);
      @(negedge clk);
      start = 1'b1; opcode = 3'(op);
      @(negedge clk);
      chk("R2", "busy after accept", int'(busy), 1);
      for (int k = 0; k < CW; k++) begin
         a_bit = av[k]; b_bit = bv[k]; c_bit = cv[k];
         if (poke && k == 5) begin
            start = 1'b1; opcode = 3'd6; rd_addr = 6'd0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R2", "done not early", int'(done), 0);
      @(negedge clk);
      chk("R2", "done pulse", int'(done), 1);
      chk("R2", "busy low at done", int'(busy), 0);
      chk("R9", "rd_rgb held while busy", int'(rd_rgb), rd_exp);
      model_apply(op, a, b, c);
      @(negedge clk);
      chk("R2", "done single cycle", int'(done), 0);
   endtask

   task automatic read_px(string req, int i);
      int exp;
      rd_addr = 6'(i);
      @(negedge clk);
      exp = (m_r[i] << 16) | (m_g[i] << 8) | m_b[i];
      chk(req, $sformatf("pixel %0d", i), int'(rd_rgb), exp);
      rd_exp = int'(rd_rgb);
   endtask

   task automatic check_image(string req);
      for (int i = 0; i < N; i++) read_px(req, i);
   endtask

   task automatic t_reset;
      for (int i = 0; i < N; i++) begin
         m_en[i] = 1'b1; m_pass[i] = 1'b0; m_dep[i] = DEPMAX;
         m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
      end
      rd_exp = 0;
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "rd_rgb after reset", int'(rd_rgb), 0);
      check_image("R1");
   endtask

   // First triangle: edges start from the reset enables (R1), x>=1, y>=1, x+y<=7.
   task automatic t_triangle;
      run_cmd(1, 1, 0, -1, 0);     // R4
      run_cmd(1, 0, 1, -1, 0);     // R4
      run_cmd(1, -1, -1, 7, 0);    // R4, zero keeps enable
      run_cmd(2, 0, 0, 100, 0);    // R6
      run_cmd(3, 60, 0, -70, 0);   // R7 saturates at both ends
      run_cmd(4, 0, 0, 128, 0);    // R7
      run_cmd(5, 0, 30, 0, 0);     // R7, R3 row term
      check_image("R3/R4/R7");
   endtask

   // Second triangle: depth crosses 100 exactly at y=6 (tie must not pass).
   task automatic t_overlap;
      run_cmd(0, 0, 0, 0, 0);      // R5
      run_cmd(1, -1, 0, 4, 0);     // R4
      run_cmd(2, 0, 10, 40, 0);    // R6
      run_cmd(3, 0, 0, 9, 0);
      run_cmd(4, 3, -2, 9, 0);     // R3 mixed signs
      run_cmd(5, 0, 0, 9, 0);
      check_image("R6");
   endtask

   // Start during busy is ignored and the read port holds.
   task automatic t_busy;
      read_px("R9", 18);
      run_cmd(5, 0, 0, 250, 1);
      read_px("R9", 0);
      check_image("R2");
   endtask

   task automatic t_nop;
      run_cmd(7, 5, 5, 5, 0);      // R10
      run_cmd(3, -7, 1, 200, 0);
      check_image("R10");
   endtask

   task automatic t_enable_reset;
      run_cmd(1, 0, 0, -1000, 0);  // clears all enables
      run_cmd(4, 0, 0, 33, 0);     // no write anywhere
      run_cmd(0, 0, 0, 0, 0);      // R5
      run_cmd(2, 0, 0, -5000, 0);
      run_cmd(3, 0, 0, 77, 0);
      check_image("R5");
   endtask

   task automatic t_clear;
      run_cmd(6, 1, 2, 3, 0);      // R8
      check_image("R8");
      run_cmd(3, 0, 0, 5, 0);      // pass cleared: no write
      run_cmd(2, 0, 0, 32767, 0);  // depth far again: passes
      run_cmd(3, 0, 0, 5, 0);
      check_image("R8 depth far");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_triangle();
      t_overlap();
      t_busy();
      t_nop();
      t_enable_reset();
      t_clear();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule